// File: doc/BRIEF.md
# Masked Processor-Interface Exception Capture Register

This block collects single-cycle error pulses from the processor interface and the memory data path into one 32-bit sticky status word, gated by a companion 32-bit enable mask. Twelve event lines feed it: a remap-table fault, a status error, a data error, a handshake error and an addressing error on each of two processor ports, and a correctable and an uncorrectable ECC error for each half of the data word. Software reaches both words over a simple single-cycle register port. Reading the status word returns what has been captured and empties it in the same access. The mask word is an ordinary read/write register.

The register uses most-significant-first numbering: bit k of the word is vector position 31-k. From the captured bits the block derives a registered interrupt, which is the OR of the captured bits that are still enabled. It also derives three registered group flags: one for processor faults, one for uncorrectable ECC and one for correctable ECC. All enable bits come out of reset set, so detection is active from the first cycle.

Top module: `exc_status_regs`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask word reads 0xFEF00000, and irq_o, cpu_fault_o, ue_fault_o and ce_fault_o are all 0.
- R2: Event line evt_i[k] maps to register bit k, which is rdata_o position 31-k. The lines are: 0 remap-table fault, 1 and 2 handshake error on port 0 and port 1, 3 status error, 4 data error, 5 and 6 addressing error on port 0 and port 1, 7 reserved, 8 upper-half uncorrectable ECC, 9 upper-half correctable ECC, 10 lower-half uncorrectable ECC, 11 lower-half correctable ECC.
- R3: An event is captured at a clock edge only if its mask bit, as held before that edge, is 1. Otherwise it leaves the status word unchanged.
- R4: A captured status bit stays set across any number of cycles until the status word is read.
- R5: A read (req_i=1, we_i=0) places the addressed word on rdata_o from the next cycle on, and rdata_o holds that value until the next read. A read of the status word (address 0x0) clears it.
- R6: An enabled event that arrives in the same cycle as a clearing status read is absent from that read's data and is still captured afterwards.
- R7: A write to the mask word (address 0x4) stores wdata_i AND 0xFEF00000. Bit 7 and bits 12 to 31 always read as 0. Reading the mask word does not change it.
- R8: Writes to the status word are ignored.
- R9: irq_o is 1 exactly one cycle after (status AND mask) is nonzero. Clearing the mask bits of captured events drops irq_o one cycle later without clearing the status word.
- R10: One cycle after the status word changes, cpu_fault_o reflects bits 0 to 6, ue_fault_o reflects bits 8 and 10, and ce_fault_o reflects bits 9 and 11.
- R11: A read of any other address returns 0, and a write to any other address changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address: 0x0 status, 0x4 mask |
| wdata_i | input | 32 | Write data |
| evt_i | input | 12 | Error event pulses, index = register bit number |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered OR of captured and enabled bits |
| cpu_fault_o | output | 1 | Registered processor-fault group flag |
| ue_fault_o | output | 1 | Registered uncorrectable-ECC group flag |
| ce_fault_o | output | 1 | Registered correctable-ECC group flag |

## Verification
On every cycle the assertions check these properties: captured bits persist unless a clearing read occurs, an enabled event is never lost even when it collides with a clearing read, the mask changes only on a write to its address, and a status read returns the previous contents. They also check that the interrupt only rises after an enabled bit was present, and that a group flag only falls two edges after a clearing read. The MSB-first mapping of each event line, the exact reset value, the silent dropping of writes to reserved bits and of writes to the status word, and decoding of unmapped addresses are behaviours that only the bench's scenarios show. The bench exercises these with directed cases and compares every output cycle by cycle against its own model during a long run of random traffic.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_EVT = 12;

    // register bit numbers (bit 0 is the most significant position)
    localparam int EV_REMAP  = 0;
    localparam int EV_HS0    = 1;
    localparam int EV_HS1    = 2;
    localparam int EV_STATUS = 3;
    localparam int EV_DATA   = 4;
    localparam int EV_ADR0   = 5;
    localparam int EV_ADR1   = 6;
    localparam int EV_UE_HI  = 8;
    localparam int EV_CE_HI  = 9;
    localparam int EV_UE_LO  = 10;
    localparam int EV_CE_LO  = 11;

    function automatic logic [REG_W-1:0] msb_bit(input int k);
        return {{(REG_W-1){1'b0}}, 1'b1} << (REG_W - 1 - k);
    endfunction

    function automatic logic [REG_W-1:0] range_bits(input int lo, input int hi, input int step);
        logic [REG_W-1:0] v;
        v = '0;
        for (int k = lo; k <= hi; k += step) begin
            v |= msb_bit(k);
        end
        return v;
    endfunction

    localparam logic [REG_W-1:0] CPU_BITS   = range_bits(EV_REMAP, EV_ADR1, 1);
    localparam logic [REG_W-1:0] UE_BITS    = range_bits(EV_UE_HI, EV_UE_LO, 2);
    localparam logic [REG_W-1:0] CE_BITS    = range_bits(EV_CE_HI, EV_CE_LO, 2);
    localparam logic [REG_W-1:0] VALID_BITS = CPU_BITS | UE_BITS | CE_BITS;
    localparam logic [REG_W-1:0] MASK_RST   = VALID_BITS;

endpackage

// File: rtl/exc_capture.sv
module exc_capture
    import exc_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [W-1:0] mask_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] stat;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [W-1:0] evt_pos;
    logic [W-1:0] hit;

    // place event k at MSB-first position k
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_map
            assign evt_pos[W-1-g] = evt_i[g];
        end
        if (W > N) begin : g_pad
            assign evt_pos[W-N-1:0] = '0;
        end
    endgenerate

    assign hit = evt_pos & mask_i & VALID_BITS;

    always_comb begin
        cap_d = cap_q;
        if (clr_i) begin
            cap_d.stat = '0;
        end
        cap_d.stat = cap_d.stat | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign stat_o = cap_q.stat;

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((cap_q.stat & $past(cap_q.stat)) == $past(cap_q.stat)));

    // R6
    no_lost_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((cap_q.stat & $past(hit)) == $past(hit)));

    // R3
    masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && (hit == '0) |=> (cap_q.stat == '0));

endmodule

// File: rtl/exc_mask_reg.sv
module exc_mask_reg
    import exc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] mask;
    } msk_t;

    msk_t msk_d, msk_q;

    always_comb begin
        msk_d = msk_q;
        if (wr_i) begin
            msk_d.mask = wdata_i & VALID_BITS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_q.mask <= MASK_RST;
        end else begin
            msk_q <= msk_d;
        end
    end

    assign mask_o = msk_q.mask;

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(msk_q.mask));

endmodule

// File: rtl/exc_summary.sv
module exc_summary
    import exc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o,
    output logic         cpu_o,
    output logic         ue_o,
    output logic         ce_o
);

    typedef struct packed {
        logic irq;
        logic cpu;
        logic ue;
        logic ce;
    } sum_t;

    sum_t sum_d, sum_q;

    always_comb begin
        sum_d     = sum_q;
        sum_d.irq = |(stat_i & mask_i);
        sum_d.cpu = |(stat_i & CPU_BITS);
        sum_d.ue  = |(stat_i & UE_BITS);
        sum_d.ce  = |(stat_i & CE_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign irq_o = sum_q.irq;
    assign cpu_o = sum_q.cpu;
    assign ue_o  = sum_q.ue;
    assign ce_o  = sum_q.ce;

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_q.irq) |-> ($past(stat_i & mask_i) != '0));

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
    import exc_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'h4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               irq_o,
    output logic               cpu_fault_o,
    output logic               ue_fault_o,
    output logic               ce_fault_o
);

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic             sel_stat, sel_mask;
    logic             rd_stat, wr_mask;
    logic [REG_W-1:0] stat_w, mask_w;

    assign sel_stat = (addr_i == STAT_ADDR);
    assign sel_mask = (addr_i == MASK_ADDR);
    assign rd_stat  = req_i && !we_i && sel_stat;
    assign wr_mask  = req_i && we_i && sel_mask;

    exc_capture #(.W(REG_W), .N(NUM_EVT)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .mask_i (mask_w),
        .clr_i  (rd_stat),
        .stat_o (stat_w)
    );

    exc_mask_reg #(.W(REG_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (wdata_i),
        .mask_o  (mask_w)
    );

    exc_summary #(.W(REG_W)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_w),
        .mask_i (mask_w),
        .irq_o  (irq_o),
        .cpu_o  (cpu_fault_o),
        .ue_o   (ue_fault_o),
        .ce_o   (ce_fault_o)
    );

    always_comb begin
        rd_d = rd_q;
        if (req_i && !we_i) begin
            if (sel_stat) begin
                rd_d.rdata = stat_w;
            end else if (sel_mask) begin
                rd_d.rdata = mask_w;
            end else begin
                rd_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;

    // R5
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (rdata_o == $past(stat_w)));

    // R10
    group_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_fault_o) |-> $past(rd_stat, 2));

endmodule

// File: tb/exc_status_regs_tb.sv
module exc_status_regs_tb;

    localparam logic [31:0] VALID = 32'hFEF0_0000;
    localparam logic [31:0] CPUB  = 32'hFE00_0000;
    localparam logic [31:0] UEB   = 32'h00A0_0000;
    localparam logic [31:0] CEB   = 32'h0050_0000;
    localparam logic [3:0]  A_ST  = 4'h0;
    localparam logic [3:0]  A_MK  = 4'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [11:0] evt_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, cpu_fault_o, ue_fault_o, ce_fault_o;

    int checks = 0;
    int errors = 0;

    // model state
    logic [31:0] m_stat, m_mask, m_rdata;
    logic        m_irq, m_cpu, m_ue, m_ce;

    always #2.5 clk = ~clk;

    exc_status_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .evt_i(evt_i), .rdata_o(rdata_o), .irq_o(irq_o),
        .cpu_fault_o(cpu_fault_o), .ue_fault_o(ue_fault_o), .ce_fault_o(ce_fault_o)
    );

    function automatic logic [31:0] evt_to_word(input logic [11:0] e);
        logic [31:0] w = '0;
        for (int k = 0; k < 12; k++) if (e[k]) w[31-k] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] read_value(input logic [3:0] a, input logic [31:0] s,
                                               input logic [31:0] m);
        if (a == A_ST) return s;
        if (a == A_MK) return m;
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R5 rdata"}, rdata_o, m_rdata);
        chk({tag, " R9 irq"}, {31'b0, irq_o}, {31'b0, m_irq});
        chk({tag, " R10 cpu"}, {31'b0, cpu_fault_o}, {31'b0, m_cpu});
        chk({tag, " R10 ue"}, {31'b0, ue_fault_o}, {31'b0, m_ue});
        chk({tag, " R10 ce"}, {31'b0, ce_fault_o}, {31'b0, m_ce});
    endtask

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic cyc(input logic r, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input logic [11:0] e, input string tag);
        logic [31:0] s0, k0;
        req_i = r; we_i = w; addr_i = a; wdata_i = d; evt_i = e;
        @(posedge clk);
        s0 = m_stat; k0 = m_mask;
        if (r && !w) m_rdata = read_value(a, s0, k0);
        m_irq = |(s0 & k0);
        m_cpu = |(s0 & CPUB);
        m_ue  = |(s0 & UEB);
        m_ce  = |(s0 & CEB);
        m_stat = ((r && !w && a == A_ST) ? 32'h0 : s0) | (evt_to_word(e) & k0 & VALID);
        if (r && w && a == A_MK) m_mask = d & VALID;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0; evt_i = '0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, A_ST, 32'h0, 12'h0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'h0, 12'h0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, 12'h0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));
        m_stat = '0; m_mask = VALID; m_rdata = '0;
        m_irq = 0; m_cpu = 0; m_ue = 0; m_ce = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata_o, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rd(A_MK, "R1");
        chk("R1 mask reset", rdata_o, 32'hFEF0_0000);
        rd(A_ST, "R1");
        chk("R1 status reset", rdata_o, 32'h0);

        // R2 MSB-first mapping
        cyc(0, 0, A_ST, 0, 12'h001, "R2");
        idle("R2");
        chk("R2 irq after latch", {31'b0, irq_o}, 32'h1);
        rd(A_ST, "R2");
        chk("R2 bit0 position", rdata_o, 32'h8000_0000);
        cyc(0, 0, A_ST, 0, 12'h800, "R2");
        rd(A_ST, "R2");
        chk("R2 bit11 position", rdata_o, 32'h0010_0000);
        idle("R2");

        // R3 masked event ignored
        wr(A_MK, 32'hEEF0_0000, "R3");
        cyc(0, 0, A_ST, 0, 12'h008, "R3");
        idle("R3");
        chk("R3 irq stays low", {31'b0, irq_o}, 32'h0);
        rd(A_ST, "R3");
        chk("R3 masked not latched", rdata_o, 32'h0);
        wr(A_MK, VALID, "R3");

        // R4 sticky, R5 read clears
        cyc(0, 0, A_ST, 0, 12'h300, "R4");
        repeat (5) idle("R4");
        chk("R4 ue held", {31'b0, ue_fault_o}, 32'h1);
        rd(A_ST, "R4");
        chk("R4 sticky value", rdata_o, 32'h00C0_0000);
        rd(A_ST, "R5");
        chk("R5 cleared after read", rdata_o, 32'h0);

        // R6 event during clearing read
        cyc(0, 0, A_ST, 0, 12'h002, "R6");
        cyc(1, 0, A_ST, 0, 12'h004, "R6");
        chk("R6 read data excludes new", rdata_o, 32'h4000_0000);
        rd(A_ST, "R6");
        chk("R6 new event kept", rdata_o, 32'h2000_0000);

        // R7 reserved bits and mask read side effect
        wr(A_MK, 32'hFFFF_FFFF, "R7");
        rd(A_MK, "R7");
        chk("R7 reserved zero", rdata_o, 32'hFEF0_0000);
        rd(A_MK, "R7");
        chk("R7 mask read no change", rdata_o, 32'hFEF0_0000);
        cyc(0, 0, A_ST, 0, 12'h080, "R7");
        rd(A_ST, "R7");
        chk("R7 reserved event ignored", rdata_o, 32'h0);

        // R8 status writes ignored
        wr(A_ST, 32'hFFFF_FFFF, "R8");
        rd(A_ST, "R8");
        chk("R8 status write ignored", rdata_o, 32'h0);

        // R9 mask removal drops irq without clearing
        cyc(0, 0, A_ST, 0, 12'h010, "R9");
        idle("R9");
        chk("R9 irq high", {31'b0, irq_o}, 32'h1);
        wr(A_MK, 32'h0, "R9");
        idle("R9");
        chk("R9 irq dropped", {31'b0, irq_o}, 32'h0);
        chk("R10 cpu still set", {31'b0, cpu_fault_o}, 32'h1);
        rd(A_ST, "R9");
        chk("R9 status kept", rdata_o, 32'h0800_0000);
        wr(A_MK, VALID, "R9");

        // R11 unmapped address
        wr(4'h8, 32'h0, "R11");
        rd(A_MK, "R11");
        chk("R11 write elsewhere", rdata_o, VALID);
        rd(4'hC, "R11");
        chk("R11 unmapped read", rdata_o, 32'h0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic r, w;
            logic [3:0] a;
            logic [11:0] e;
            r = ($urandom % 4) == 0;
            w = ($urandom % 3) == 0;
            case ($urandom % 5)
                0, 1:    a = A_ST;
                2, 3:    a = A_MK;
                default: a = 4'($urandom);
            endcase
            e = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
            cyc(r, w, a, $urandom, e, "R3 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule